// File: doc/BRIEF.md
# Group Request Scheduler

This block collects save and restore requests for a set of descriptor groups and decides which group the descriptor engine works on next. Requests arrive two ways. Hardware power-controller request lines are edge-detected. Software trigger writes name a group and a direction. The block keeps four pending bitmaps: hardware save, hardware restore, software save and software restore. All four can be read at the ports.

Each group has two priorities, one for save and one for restore. A lower value wins. The block picks among enabled groups that are pending in exactly one direction. The winner is the group with the lowest priority value in its pending direction, and ties go to the lower group index. The chosen group index, direction and a software-origin flag are held at the dispatch outputs until the engine reports done or error. The group's pending bits for that direction are then cleared. A group pending for save and restore at once is in conflict: it is flagged and held back until one request is withdrawn.

Top module: `grp_req_sched`

## Requirements
- R1: With the default parameters there are 16 groups. Bit g of each of the four 16-bit pending outputs belongs to group g.
- R2: A write with `sw_wr_valid` high and `sw_wr_cancel` low sets the software pending bit of group `sw_wr_grp`. Direction 0 selects save and direction 1 selects restore. This works whatever the hardware-disable input is. A write with `sw_wr_cancel` high clears that bit instead. The pending output shows the change in the cycle after the write.
- R3: A rising edge on `hw_save_line[g]` or `hw_rest_line[g]` sets the matching hardware pending bit one cycle later, unless `hw_req_block` is high. A line held high while blocked never sets the bit, even after the block is removed. A falling edge clears the bit, which withdraws the request.
- R4: The winner is the eligible group with the lowest priority in its pending direction. Save priorities are taken from `save_prio_flat[g*4 +: 4]` and restore priorities from `rest_prio_flat[g*4 +: 4]`. 0 is the highest priority and 15 the lowest.
- R5: When two eligible groups have equal priority, the lower group index is dispatched first.
- R6: A group whose `grp_en` bit is low is never dispatched, and its pending bits are kept. It is dispatched once the bit is set again.
- R7: When a group is pending for save and restore at the same time, `conflict_pulse` goes high for one cycle, two cycles after the requests arrive. The group is not dispatched until one of the two is withdrawn.
- R8: Only one group is dispatched at a time. `disp_valid` rises in the cycle after the pending bit becomes visible. It stays high with stable group and direction until done or error. After that it is low for exactly one cycle, and then the next selection appears.
- R9: Done or error clears both the hardware and the software pending bits of the dispatched group in the dispatched direction.
- R10: `sw_done` pulses for one cycle after a done, not an error, for an operation whose software pending bit was set at completion.
- R11: After reset all pending bitmaps are zero, and `disp_valid`, `sw_done` and `conflict_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_save_line | input | 16 | Hardware save request lines, one per group |
| hw_rest_line | input | 16 | Hardware restore request lines, one per group |
| hw_req_block | input | 1 | Global disable for new hardware requests |
| sw_wr_valid | input | 1 | Software trigger write strobe |
| sw_wr_grp | input | 4 | Group addressed by the software write |
| sw_wr_dir | input | 1 | Direction of the software write: 0 save, 1 restore |
| sw_wr_cancel | input | 1 | The software write clears instead of sets |
| grp_en | input | 16 | Per-group enable |
| save_prio_flat | input | 64 | Save priority of each group, 4 bits per group |
| rest_prio_flat | input | 64 | Restore priority of each group, 4 bits per group |
| eng_done | input | 1 | Engine finished the dispatched group |
| eng_err | input | 1 | Engine aborted the dispatched group |
| hw_save_pend | output | 16 | Hardware save pending bitmap |
| hw_rest_pend | output | 16 | Hardware restore pending bitmap |
| sw_save_pend | output | 16 | Software save pending bitmap |
| sw_rest_pend | output | 16 | Software restore pending bitmap |
| disp_valid | output | 1 | A group is dispatched to the engine |
| disp_grp | output | 4 | Dispatched group index |
| disp_dir | output | 1 | Dispatched direction: 0 save, 1 restore |
| disp_sw | output | 1 | The software pending bit was set at dispatch |
| sw_done | output | 1 | Software-requested operation completed |
| conflict_pulse | output | 1 | A group newly entered save/restore conflict |

## Verification
The bench uses the default build: 16 groups with 4-bit priorities. This build lets it reach the top group index 15 in a tie and both ends of the priority range (0 and 15). Running save and restore against each other on one group shows that each direction's priority field is decoded on its own. With this size the arbitration covers every index bit and every priority bit, so a fault in the compare chain or in the field slicing changes which group is dispatched.

// File: rtl/grs_pkg.sv
package grs_pkg;
   typedef enum logic {
      GRS_SAVE    = 1'b0,
      GRS_RESTORE = 1'b1
   } grs_dir_e;
endpackage

// File: rtl/grs_pend_track.sv
module grs_pend_track
   import grs_pkg::*;
#(
   parameter int unsigned NUM_GRP = 16,
   localparam int unsigned GRP_W = $clog2(NUM_GRP)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_GRP-1:0] hw_save_line,
   input  logic [NUM_GRP-1:0] hw_rest_line,
   input  logic               hw_block,
   input  logic               sw_wr_valid,
   input  logic [GRP_W-1:0]   sw_wr_grp,
   input  grs_dir_e           sw_wr_dir,
   input  logic               sw_wr_cancel,
   input  logic               cmp_valid,
   input  logic [GRP_W-1:0]   cmp_grp,
   input  grs_dir_e           cmp_dir,
   output logic [NUM_GRP-1:0] hw_save_pend,
   output logic [NUM_GRP-1:0] hw_rest_pend,
   output logic [NUM_GRP-1:0] sw_save_pend,
   output logic [NUM_GRP-1:0] sw_rest_pend
);

   if (NUM_GRP < 2) begin : g_bad_num
      $error("grs_pend_track: NUM_GRP must be at least 2");
   end

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic hs_q, hr_q;
      logic hs_p, hr_p, ss_p, sr_p;
      logic wr_hit, cmp_hit;
      logic hs_rise, hs_fall, hr_rise, hr_fall;
      logic ss_set, ss_clr, sr_set, sr_clr;

      assign wr_hit  = sw_wr_valid && (sw_wr_grp == GRP_W'(g));
      assign cmp_hit = cmp_valid && (cmp_grp == GRP_W'(g));

      assign hs_rise = hw_save_line[g] && !hs_q && !hw_block;
      assign hr_rise = hw_rest_line[g] && !hr_q && !hw_block;
      assign hs_fall = !hw_save_line[g] && hs_q;
      assign hr_fall = !hw_rest_line[g] && hr_q;

      assign ss_set = wr_hit && !sw_wr_cancel && (sw_wr_dir == GRS_SAVE);
      assign sr_set = wr_hit && !sw_wr_cancel && (sw_wr_dir == GRS_RESTORE);
      assign ss_clr = (wr_hit && sw_wr_cancel && (sw_wr_dir == GRS_SAVE)) ||
                      (cmp_hit && (cmp_dir == GRS_SAVE));
      assign sr_clr = (wr_hit && sw_wr_cancel && (sw_wr_dir == GRS_RESTORE)) ||
                      (cmp_hit && (cmp_dir == GRS_RESTORE));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hs_q <= 1'b0;
            hr_q <= 1'b0;
            hs_p <= 1'b0;
            hr_p <= 1'b0;
            ss_p <= 1'b0;
            sr_p <= 1'b0;
         end else begin
            hs_q <= hw_save_line[g];
            hr_q <= hw_rest_line[g];
            if (hs_rise)
               hs_p <= 1'b1;
            else if (hs_fall || (cmp_hit && cmp_dir == GRS_SAVE))
               hs_p <= 1'b0;
            if (hr_rise)
               hr_p <= 1'b1;
            else if (hr_fall || (cmp_hit && cmp_dir == GRS_RESTORE))
               hr_p <= 1'b0;
            if (ss_set)
               ss_p <= 1'b1;
            else if (ss_clr)
               ss_p <= 1'b0;
            if (sr_set)
               sr_p <= 1'b1;
            else if (sr_clr)
               sr_p <= 1'b0;
         end
      end

      assign hw_save_pend[g] = hs_p;
      assign hw_rest_pend[g] = hr_p;
      assign sw_save_pend[g] = ss_p;
      assign sw_rest_pend[g] = sr_p;
   end

   // R3
   hw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_block |=> (((hw_save_pend & ~$past(hw_save_pend)) == '0) &&
                    ((hw_rest_pend & ~$past(hw_rest_pend)) == '0)));

endmodule

// File: rtl/grs_arbiter.sv
module grs_arbiter
   import grs_pkg::*;
#(
   parameter int unsigned NUM_GRP = 16,
   parameter int unsigned PRIO_W  = 4,
   localparam int unsigned GRP_W  = $clog2(NUM_GRP)
) (
   input  logic [NUM_GRP-1:0]        save_need,
   input  logic [NUM_GRP-1:0]        rest_need,
   input  logic [NUM_GRP-1:0]        grp_en,
   input  logic [NUM_GRP*PRIO_W-1:0] save_prio_flat,
   input  logic [NUM_GRP*PRIO_W-1:0] rest_prio_flat,
   output logic                      any_elig,
   output logic [GRP_W-1:0]          win_grp,
   output grs_dir_e                  win_dir,
   output logic [NUM_GRP-1:0]        conflict_vec
);

   if (PRIO_W < 1) begin : g_bad_prio
      $error("grs_arbiter: PRIO_W must be at least 1");
   end

   logic [NUM_GRP-1:0] elig;
   logic [NUM_GRP-1:0] elig_rest;
   logic [PRIO_W-1:0]  key [NUM_GRP];

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_key
      logic s_only, r_only;
      assign s_only          = save_need[g] && !rest_need[g];
      assign r_only          = rest_need[g] && !save_need[g];
      assign conflict_vec[g] = save_need[g] && rest_need[g];
      assign elig[g]         = grp_en[g] && (s_only || r_only);
      assign elig_rest[g]    = r_only;
      assign key[g]          = r_only ? rest_prio_flat[g*PRIO_W +: PRIO_W]
                                      : save_prio_flat[g*PRIO_W +: PRIO_W];
   end

   always_comb begin
      logic [PRIO_W-1:0] best;
      logic              found;
      found   = 1'b0;
      best    = '0;
      win_grp = '0;
      win_dir = GRS_SAVE;
      for (int i = 0; i < NUM_GRP; i++) begin
         if (elig[i] && (!found || key[i] < best)) begin
            found   = 1'b1;
            best    = key[i];
            win_grp = GRP_W'(i);
            win_dir = elig_rest[i] ? GRS_RESTORE : GRS_SAVE;
         end
      end
      any_elig = found;
   end

endmodule

// File: rtl/grs_dispatch.sv
module grs_dispatch
   import grs_pkg::*;
#(
   parameter int unsigned NUM_GRP = 16,
   localparam int unsigned GRP_W  = $clog2(NUM_GRP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_elig,
   input  logic [GRP_W-1:0] win_grp,
   input  grs_dir_e         win_dir,
   input  logic             win_sw,
   input  logic             sw_at_cmp,
   input  logic             eng_done,
   input  logic             eng_err,
   output logic             disp_valid,
   output logic [GRP_W-1:0] disp_grp,
   output grs_dir_e         disp_dir,
   output logic             disp_sw,
   output logic             cmp_valid,
   output logic             sw_done
);

   logic finish;
   assign finish    = eng_done || eng_err;
   assign cmp_valid = disp_valid && finish;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_valid <= 1'b0;
         disp_grp   <= '0;
         disp_dir   <= GRS_SAVE;
         disp_sw    <= 1'b0;
         sw_done    <= 1'b0;
      end else begin
         sw_done <= 1'b0;
         if (disp_valid) begin
            if (finish) begin
               disp_valid <= 1'b0;
               sw_done    <= eng_done && !eng_err && sw_at_cmp;
            end
         end else if (any_elig) begin
            disp_valid <= 1'b1;
            disp_grp   <= win_grp;
            disp_dir   <= win_dir;
            disp_sw    <= win_sw;
         end
      end
   end

   // R8
   disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && !finish |=> disp_valid && $stable(disp_grp) && $stable(disp_dir));

   // R8
   disp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && finish |=> !disp_valid);

   // R10
   sw_done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_done |-> $past(eng_done) && !$past(eng_err) && $past(disp_valid));

endmodule

// File: rtl/grp_req_sched.sv
module grp_req_sched
   import grs_pkg::*;
#(
   parameter int unsigned NUM_GRP = 16,
   parameter int unsigned PRIO_W  = 4,
   localparam int unsigned GRP_W  = $clog2(NUM_GRP)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_GRP-1:0]        hw_save_line,
   input  logic [NUM_GRP-1:0]        hw_rest_line,
   input  logic                      hw_req_block,
   input  logic                      sw_wr_valid,
   input  logic [GRP_W-1:0]          sw_wr_grp,
   input  logic                      sw_wr_dir,
   input  logic                      sw_wr_cancel,
   input  logic [NUM_GRP-1:0]        grp_en,
   input  logic [NUM_GRP*PRIO_W-1:0] save_prio_flat,
   input  logic [NUM_GRP*PRIO_W-1:0] rest_prio_flat,
   input  logic                      eng_done,
   input  logic                      eng_err,
   output logic [NUM_GRP-1:0]        hw_save_pend,
   output logic [NUM_GRP-1:0]        hw_rest_pend,
   output logic [NUM_GRP-1:0]        sw_save_pend,
   output logic [NUM_GRP-1:0]        sw_rest_pend,
   output logic                      disp_valid,
   output logic [GRP_W-1:0]          disp_grp,
   output logic                      disp_dir,
   output logic                      disp_sw,
   output logic                      sw_done,
   output logic                      conflict_pulse
);

   logic               any_elig, win_sw, sw_at_cmp, cmp_valid;
   logic [GRP_W-1:0]   win_grp;
   grs_dir_e           win_dir, d_dir;
   logic [NUM_GRP-1:0] conflict_vec, conflict_q;

   grs_pend_track #(.NUM_GRP(NUM_GRP)) u_pend (
      .clk          (clk),
      .rst_n        (rst_n),
      .hw_save_line (hw_save_line),
      .hw_rest_line (hw_rest_line),
      .hw_block     (hw_req_block),
      .sw_wr_valid  (sw_wr_valid),
      .sw_wr_grp    (sw_wr_grp),
      .sw_wr_dir    (grs_dir_e'(sw_wr_dir)),
      .sw_wr_cancel (sw_wr_cancel),
      .cmp_valid    (cmp_valid),
      .cmp_grp      (disp_grp),
      .cmp_dir      (d_dir),
      .hw_save_pend (hw_save_pend),
      .hw_rest_pend (hw_rest_pend),
      .sw_save_pend (sw_save_pend),
      .sw_rest_pend (sw_rest_pend)
   );

   grs_arbiter #(.NUM_GRP(NUM_GRP), .PRIO_W(PRIO_W)) u_arb (
      .save_need      (hw_save_pend | sw_save_pend),
      .rest_need      (hw_rest_pend | sw_rest_pend),
      .grp_en         (grp_en),
      .save_prio_flat (save_prio_flat),
      .rest_prio_flat (rest_prio_flat),
      .any_elig       (any_elig),
      .win_grp        (win_grp),
      .win_dir        (win_dir),
      .conflict_vec   (conflict_vec)
   );

   assign win_sw    = (win_dir == GRS_RESTORE) ? sw_rest_pend[win_grp] : sw_save_pend[win_grp];
   assign sw_at_cmp = (d_dir == GRS_RESTORE) ? sw_rest_pend[disp_grp] : sw_save_pend[disp_grp];

   grs_dispatch #(.NUM_GRP(NUM_GRP)) u_disp (
      .clk        (clk),
      .rst_n      (rst_n),
      .any_elig   (any_elig),
      .win_grp    (win_grp),
      .win_dir    (win_dir),
      .win_sw     (win_sw),
      .sw_at_cmp  (sw_at_cmp),
      .eng_done   (eng_done),
      .eng_err    (eng_err),
      .disp_valid (disp_valid),
      .disp_grp   (disp_grp),
      .disp_dir   (d_dir),
      .disp_sw    (disp_sw),
      .cmp_valid  (cmp_valid),
      .sw_done    (sw_done)
   );

   assign disp_dir = (d_dir == GRS_RESTORE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conflict_q     <= '0;
         conflict_pulse <= 1'b0;
      end else begin
         conflict_q     <= conflict_vec;
         conflict_pulse <= |(conflict_vec & ~conflict_q);
      end
   end

   // R6
   en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_valid) |-> ((($past(grp_en) >> disp_grp) & 1) != 0));

   // R7
   conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_valid) |-> ((($past(conflict_vec) >> disp_grp) & 1) == 0));

endmodule

// File: tb/grp_req_sched_test.sv
`timescale 1ns/1ps
module grp_req_sched_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] hw_save_line = '0, hw_rest_line = '0, grp_en = '1;
   logic        hw_req_block = 1'b0;
   logic        sw_wr_valid = 1'b0, sw_wr_dir = 1'b0, sw_wr_cancel = 1'b0;
   logic [3:0]  sw_wr_grp = '0;
   logic        eng_done = 1'b0, eng_err = 1'b0;
   logic [3:0]  sp [16];
   logic [3:0]  rp [16];
   logic [63:0] save_prio_flat, rest_prio_flat;
   logic [15:0] hw_save_pend, hw_rest_pend, sw_save_pend, sw_rest_pend;
   logic        disp_valid, disp_dir, disp_sw, sw_done, conflict_pulse;
   logic [3:0]  disp_grp;
   int          n_chk = 0, n_bad = 0;
   bit          all_done = 1'b0;

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 16; i++) begin
         save_prio_flat[i*4 +: 4] = sp[i];
         rest_prio_flat[i*4 +: 4] = rp[i];
      end
   end

   grp_req_sched uut (
      .clk(clk), .rst_n(rst_n), .hw_save_line(hw_save_line), .hw_rest_line(hw_rest_line),
      .hw_req_block(hw_req_block), .sw_wr_valid(sw_wr_valid), .sw_wr_grp(sw_wr_grp),
      .sw_wr_dir(sw_wr_dir), .sw_wr_cancel(sw_wr_cancel), .grp_en(grp_en),
      .save_prio_flat(save_prio_flat), .rest_prio_flat(rest_prio_flat),
      .eng_done(eng_done), .eng_err(eng_err), .hw_save_pend(hw_save_pend),
      .hw_rest_pend(hw_rest_pend), .sw_save_pend(sw_save_pend), .sw_rest_pend(sw_rest_pend),
      .disp_valid(disp_valid), .disp_grp(disp_grp), .disp_dir(disp_dir), .disp_sw(disp_sw),
      .sw_done(sw_done), .conflict_pulse(conflict_pulse));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sw_write(int g, bit dir, bit cancel);
      sw_wr_valid = 1'b1; sw_wr_grp = 4'(g); sw_wr_dir = dir; sw_wr_cancel = cancel;
      @(negedge clk);
      sw_wr_valid = 1'b0; sw_wr_cancel = 1'b0;
   endtask

   task automatic finish_op(bit err);
      if (err) eng_err = 1'b1; else eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0; eng_err = 1'b0;
   endtask

   task automatic t_reset;
      chk("R11 hw save pend", 32'(hw_save_pend), 0);
      chk("R11 hw rest pend", 32'(hw_rest_pend), 0);
      chk("R11 sw save pend", 32'(sw_save_pend), 0);
      chk("R11 sw rest pend", 32'(sw_rest_pend), 0);
      chk("R11 disp_valid", 32'(disp_valid), 0);
      chk("R11 flags", 32'({sw_done, conflict_pulse}), 0);
   endtask

   task automatic t_sw_save;
      sp[5] = 4'd3;
      sw_write(5, 1'b0, 1'b0);
      chk("R2 sw save pend", 32'(sw_save_pend), 32'h20);
      chk("R1 other maps idle", 32'(hw_save_pend | hw_rest_pend | sw_rest_pend), 0);
      chk("R8 not yet dispatched", 32'(disp_valid), 0);
      step(1);
      chk("R8 dispatch", 32'({disp_valid, disp_grp, disp_dir, disp_sw}), {28'd0, 1'b1, 4'd5, 1'b0, 1'b1} >> 0);
      step(2);
      chk("R8 held", 32'({disp_valid, disp_grp}), 32'h15);
      finish_op(1'b0);
      chk("R9 sw save cleared", 32'(sw_save_pend), 0);
      chk("R10 sw_done pulse", 32'(sw_done), 1);
      chk("R8 released", 32'(disp_valid), 0);
      step(1);
      chk("R10 sw_done one cycle", 32'(sw_done), 0);
   endtask

   task automatic t_priority;
      rp[2] = 4'd7; rp[9] = 4'd1;
      hw_rest_line[2] = 1'b1; hw_rest_line[9] = 1'b1;
      step(1);
      chk("R3 hw rest pend", 32'(hw_rest_pend), 32'h0204);
      step(1);
      chk("R4 lowest value wins", 32'({disp_valid, disp_grp, disp_dir, disp_sw}), {1'b1, 4'd9, 1'b1, 1'b0});
      finish_op(1'b0);
      chk("R9 hw bit cleared", 32'(hw_rest_pend), 32'h0004);
      chk("R8 gap cycle", 32'(disp_valid), 0);
      chk("R10 no sw_done for hw", 32'(sw_done), 0);
      step(1);
      chk("R8 next selection", 32'({disp_valid, disp_grp}), {1'b1, 4'd2});
      finish_op(1'b0);
      chk("R9 all cleared", 32'(hw_rest_pend), 0);
      hw_rest_line = '0;
      step(1);
   endtask

   task automatic t_dir_prio;
      sp[6] = 4'd0; rp[6] = 4'd15; sp[7] = 4'd4; rp[7] = 4'd0;
      hw_rest_line[6] = 1'b1; hw_save_line[7] = 1'b1;
      step(2);
      chk("R4 per-direction field", 32'({disp_valid, disp_grp, disp_dir}), {1'b1, 4'd7, 1'b0});
      finish_op(1'b0);
      step(1);
      chk("R4 lowest priority last", 32'({disp_valid, disp_grp, disp_dir}), {1'b1, 4'd6, 1'b1});
      finish_op(1'b0);
      hw_rest_line = '0; hw_save_line = '0;
      step(1);
   endtask

   task automatic t_tie;
      sp[4] = 4'd6; sp[15] = 4'd6;
      hw_save_line[4] = 1'b1; hw_save_line[15] = 1'b1;
      step(2);
      chk("R5 tie lower index", 32'({disp_valid, disp_grp}), {1'b1, 4'd4});
      finish_op(1'b0);
      step(1);
      chk("R5 tie then upper", 32'({disp_valid, disp_grp}), {1'b1, 4'd15});
      finish_op(1'b0);
      hw_save_line = '0;
      step(1);
   endtask

   task automatic t_enable;
      grp_en[8] = 1'b0;
      sw_write(8, 1'b1, 1'b0);
      step(3);
      chk("R6 disabled not dispatched", 32'(disp_valid), 0);
      chk("R6 pending kept", 32'(sw_rest_pend), 32'h0100);
      grp_en[8] = 1'b1;
      step(1);
      chk("R6 dispatched after enable", 32'({disp_valid, disp_grp, disp_dir, disp_sw}), {1'b1, 4'd8, 1'b1, 1'b1});
      finish_op(1'b0);
      chk("R10 sw restore done", 32'(sw_done), 1);
   endtask

   task automatic t_hw_block;
      hw_req_block = 1'b1;
      hw_save_line[12] = 1'b1;
      step(2);
      chk("R3 blocked edge ignored", 32'(hw_save_pend), 0);
      hw_req_block = 1'b0;
      step(2);
      chk("R3 no late pend", 32'({hw_save_pend, disp_valid}), 0);
      hw_save_line[12] = 1'b0;
      hw_req_block = 1'b1;
      sw_write(12, 1'b0, 1'b0);
      chk("R2 sw ignores hw block", 32'(sw_save_pend), 32'h1000);
      hw_req_block = 1'b0;
      step(1);
      chk("R2 dispatched", 32'({disp_valid, disp_grp}), {1'b1, 4'd12});
      finish_op(1'b0);
   endtask

   task automatic t_cancel;
      grp_en[10] = 1'b0;
      sw_write(10, 1'b0, 1'b0);
      chk("R2 set before cancel", 32'(sw_save_pend), 32'h0400);
      sw_write(10, 1'b0, 1'b1);
      chk("R2 cancel clears", 32'(sw_save_pend), 0);
      grp_en[10] = 1'b1;
      step(2);
      chk("R2 cancelled not dispatched", 32'(disp_valid), 0);
   endtask

   task automatic t_conflict;
      hw_save_line[3] = 1'b1; hw_rest_line[3] = 1'b1;
      step(1);
      chk("R7 both pending", 32'({hw_save_pend, hw_rest_pend}), {16'h0008, 16'h0008});
      chk("R7 pulse not yet", 32'(conflict_pulse), 0);
      step(1);
      chk("R7 conflict pulse", 32'(conflict_pulse), 1);
      chk("R7 held back", 32'(disp_valid), 0);
      step(1);
      chk("R7 pulse one cycle", 32'(conflict_pulse), 0);
      step(2);
      chk("R7 still held", 32'(disp_valid), 0);
      hw_rest_line[3] = 1'b0;
      step(1);
      chk("R3 withdraw clears", 32'(hw_rest_pend), 0);
      step(1);
      chk("R7 dispatched after withdraw", 32'({disp_valid, disp_grp, disp_dir}), {1'b1, 4'd3, 1'b0});
      finish_op(1'b0);
      hw_save_line = '0;
      step(1);
   endtask

   task automatic t_error;
      sw_write(13, 1'b1, 1'b0);
      step(1);
      chk("R8 dispatch 13", 32'({disp_valid, disp_grp}), {1'b1, 4'd13});
      finish_op(1'b1);
      chk("R9 error clears", 32'(sw_rest_pend), 0);
      chk("R10 no done on error", 32'(sw_done), 0);
      chk("R8 released on error", 32'(disp_valid), 0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin sp[i] = 4'd8; rp[i] = 4'd8; end
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset;
      t_sw_save;
      t_priority;
      t_dir_prio;
      t_tie;
      t_enable;
      t_hw_block;
      t_cancel;
      t_conflict;
      t_error;
      all_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!all_done) begin
         n_chk++; n_bad++;
         $display("FAIL R8 watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule